// File: doc/BRIEF.md
# Clock Loss Monitor

The block watches an external main clock from the domain of a free-running backup (ring) oscillator clock. Every rising main-clock edge flips a toggle flop. The toggle crosses into the backup domain through a two-flop synchronizer and becomes a one-cycle edge pulse there. A silence counter declares the main clock stopped when no edge arrives for `STOP_CYCLES` backup cycles. While the clock is stopped, a run counter declares a restart only after `RESTART_EDGES` edges arrive, each with a gap shorter than the stop window.

A mode bit selects the response to a detected stop. In reset mode the stop raises a system reset, and that reset holds until the external hardware reset clears it. In interrupt mode, stop and restart events raise a sticky interrupt request. If the main clock fed the CPU directly when it stopped, the block also moves the CPU clock source to the backup oscillator. If the PLL was the source, the selection is left for software to change, and a restart never changes it.

A single five-bit control/status register gives software access to these bits. Detection is only dependable when the main clock period is longer than two backup cycles and shorter than the stop window. In a real system this corresponds to a main clock of at least 2 MHz.

Top module: `clk_loss_mon`

## Requirements
- R1: After `rstN` is released, every register bit reads 0 and `clkSelBk`, `irqReq` and `sysRst` are 0. Register layout: bit 0 enable, bit 1 mode (1 = interrupt), bit 2 backup-clock select, bit 3 detect flag, bit 4 clock-stopped status (read only).
- R2: While the enable bit is 0, a stopped main clock sets neither the detect flag nor the status bit and raises no interrupt, no reset and no clock switch.
- R3: While main edges keep arriving within the window, no stop is declared. After the last edge, a stop is declared no sooner than `STOP_CYCLES` backup cycles later. The stop sets the detect flag and the clock-stopped bit to 1.
- R4: In reset mode (bit 1 = 0), a detected stop drives `sysRst` to 1 and raises no interrupt. `sysRst` stays 1 through a main-clock restart and through register writes until `rstN` is asserted.
- R5: In interrupt mode, a stop while `cpuSrcPll` = 0 raises `irqReq` and sets the select bit to 1, which drives `clkSelBk` to 1.
- R6: In interrupt mode, a stop while `cpuSrcPll` = 1 raises `irqReq` but leaves the select bit unchanged.
- R7: While stopped, `RESTART_EDGES` edges with short gaps clear the clock-stopped bit and set the detect flag. They raise `irqReq` only in interrupt mode and leave the select bit unchanged.
- R8: Fewer than `RESTART_EDGES` edges, followed by another silence of the window length, do not count as a restart: the clock-stopped bit stays 1.
- R9: A write with bit 3 = 0 clears the detect flag and `irqReq`. A write with bit 3 = 1 leaves both unchanged.
- R10: A write with bit 2 = 1 sets the select bit. A write with bit 2 = 0 clears it only while the clock-stopped bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bkClk | input | 1 | Backup oscillator clock, domain of all state except the toggle flop |
| mainClk | input | 1 | Monitored main clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| cpuSrcPll | input | 1 | 1 when the PLL output, not the main clock, drives the CPU |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 5 | Register write data |
| regRdData | output | 5 | Register read data |
| clkSelBk | output | 1 | 1 selects the backup oscillator as CPU clock source |
| irqReq | output | 1 | Sticky interrupt request |
| sysRst | output | 1 | Sticky system reset request |

## Verification
The bench sweeps all eight combinations of enable, mode and CPU source. Each combination goes through a running clock, a stop, a short burst of edges, and a full restart. With the monitor disabled, the same stop must leave every output quiet, which separates a gated monitor from one that only masks its outputs. The two modes and the two sources separate the reset, interrupt-with-switch and interrupt-without-switch responses. The short burst separates a qualified restart from a single returning edge. Writes that try to clear the select bit, issued before and after the restart, show whether the stopped status gates that write.

// File: rtl/clm_pkg.sv
package clm_pkg;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_MODE = 1;
  localparam int unsigned BIT_SEL  = 2;
  localparam int unsigned BIT_FLAG = 3;
  localparam int unsigned BIT_STOP = 4;

  typedef enum logic {
    MON_RUN     = 1'b0,
    MON_STOPPED = 1'b1
  } monState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;  // monitor enabled: silence counter may run
    logic runArm;   // stopped state: run counter may qualify a restart
  } clmStrobe_t;
endpackage

// File: rtl/clm_datapath.sv
module clm_datapath import clm_pkg::*; #(
  parameter int unsigned STOP_CYCLES   = 8,
  parameter int unsigned RESTART_EDGES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       mainClk,
  input  logic       bkClk,
  input  logic       rstN,
  input  clmStrobe_t strobe,
  output logic       edgeSeen,
  output logic       stopHit,
  output logic       restartHit
);
  localparam int unsigned SIL_W = $clog2(STOP_CYCLES + 1);
  localparam int unsigned RUN_W = $clog2(RESTART_EDGES + 1);
  localparam logic [SIL_W-1:0] SIL_MAX = SIL_W'(STOP_CYCLES);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RESTART_EDGES);

  logic mainTgl;
  logic [SYNC_STAGES:0] syncChain;
  logic [SIL_W-1:0] silenceCnt;
  logic [RUN_W-1:0] runCnt;

  // main-clock domain: one flip per rising edge
  always_ff @(posedge mainClk or negedge rstN) begin
    if (!rstN) mainTgl <= 1'b0;
    else       mainTgl <= ~mainTgl;
  end

  // synchronizer plus one history stage for edge extraction
  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], mainTgl};
  end

  assign edgeSeen = syncChain[SYNC_STAGES] ^ syncChain[SYNC_STAGES-1];

  // silence counter: saturates at the stop window
  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN)                           silenceCnt <= '0;
    else if (!strobe.countEn || edgeSeen) silenceCnt <= '0;
    else if (silenceCnt != SIL_MAX)      silenceCnt <= silenceCnt + 1'b1;
  end

  assign stopHit = (silenceCnt == SIL_MAX);

  // run counter: consecutive edges while stopped
  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN)                                 runCnt <= '0;
    else if (!strobe.runArm)                   runCnt <= '0;
    else if (edgeSeen && runCnt != RUN_MAX)    runCnt <= runCnt + 1'b1;
    else if (stopHit)                          runCnt <= '0;
  end

  assign restartHit = (runCnt == RUN_MAX);

  // R3
  silence_bound_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    silenceCnt <= SIL_MAX);

  // R8
  restart_gap_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    (stopHit && !edgeSeen && strobe.runArm) |=> (runCnt == '0));
endmodule

// File: rtl/clm_ctrl.sv
module clm_ctrl import clm_pkg::*; (
  input  logic             bkClk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             cpuSrcPll,
  input  logic             stopHit,
  input  logic             restartHit,
  output clmStrobe_t       strobe,
  output logic [REG_W-1:0] regRdData,
  output logic             clkSelBk,
  output logic             irqReq,
  output logic             sysRst
);
  monState_e state, stateNext;
  logic monEn, intMode, bkSel, detFlag, irqPend, rstLatch;
  logic stopEvt, restartEvt, flagClr, selClrReq, selSetReq;

  assign stopEvt    = monEn && (state == MON_RUN) && stopHit;
  assign restartEvt = monEn && (state == MON_STOPPED) && restartHit;
  assign flagClr    = regWrEn && !regWrData[BIT_FLAG];
  assign selSetReq  = regWrEn && regWrData[BIT_SEL];
  assign selClrReq  = regWrEn && !regWrData[BIT_SEL] && (state != MON_STOPPED);

  always_comb begin
    stateNext = state;
    if (!monEn)          stateNext = MON_RUN;
    else if (stopEvt)    stateNext = MON_STOPPED;
    else if (restartEvt) stateNext = MON_RUN;
  end

  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN) state <= MON_RUN;
    else       state <= stateNext;
  end

  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN) begin
      monEn   <= 1'b0;
      intMode <= 1'b0;
    end else if (regWrEn) begin
      monEn   <= regWrData[BIT_EN];
      intMode <= regWrData[BIT_MODE];
    end
  end

  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN)                               bkSel <= 1'b0;
    else if (stopEvt && intMode && !cpuSrcPll) bkSel <= 1'b1;
    else if (selSetReq)                      bkSel <= 1'b1;
    else if (selClrReq)                      bkSel <= 1'b0;
  end

  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN) begin
      detFlag <= 1'b0;
      irqPend <= 1'b0;
    end else begin
      if (stopEvt || restartEvt) detFlag <= 1'b1;
      else if (flagClr)          detFlag <= 1'b0;
      if ((stopEvt || restartEvt) && intMode) irqPend <= 1'b1;
      else if (flagClr)                       irqPend <= 1'b0;
    end
  end

  always_ff @(posedge bkClk or negedge rstN) begin
    if (!rstN)                    rstLatch <= 1'b0;
    else if (stopEvt && !intMode) rstLatch <= 1'b1;
  end

  assign strobe.countEn = monEn;
  assign strobe.runArm  = (state == MON_STOPPED);

  always_comb begin
    regRdData           = '0;
    regRdData[BIT_EN]   = monEn;
    regRdData[BIT_MODE] = intMode;
    regRdData[BIT_SEL]  = bkSel;
    regRdData[BIT_FLAG] = detFlag;
    regRdData[BIT_STOP] = (state == MON_STOPPED);
  end

  assign clkSelBk = bkSel;
  assign irqReq   = irqPend;
  assign sysRst   = rstLatch;

  // R2
  no_detect_when_off_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    !monEn |=> !$rose(detFlag));

  // R4
  rst_sticky_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    sysRst |=> sysRst);

  // R5
  irq_mode_only_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    $rose(irqPend) |-> $past(intMode));

  // R6
  pll_no_switch_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    (stopEvt && cpuSrcPll && !regWrEn) |=> $stable(bkSel));

  // R7
  restart_sel_stable_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    (restartEvt && !regWrEn) |=> $stable(bkSel));

  // R10
  sel_hold_stopped_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    (state == MON_STOPPED && bkSel) |=> bkSel);
endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon import clm_pkg::*; #(
  parameter int unsigned STOP_CYCLES   = 8,
  parameter int unsigned RESTART_EDGES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic             bkClk,
  input  logic             mainClk,
  input  logic             rstN,
  input  logic             cpuSrcPll,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             clkSelBk,
  output logic             irqReq,
  output logic             sysRst
);
  clmStrobe_t strobe;
  logic edgeSeen, stopHit, restartHit;

  clm_datapath #(
    .STOP_CYCLES  (STOP_CYCLES),
    .RESTART_EDGES(RESTART_EDGES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_datapath (
    .mainClk   (mainClk),
    .bkClk     (bkClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .edgeSeen  (edgeSeen),
    .stopHit   (stopHit),
    .restartHit(restartHit)
  );

  clm_ctrl u_ctrl (
    .bkClk     (bkClk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .cpuSrcPll (cpuSrcPll),
    .stopHit   (stopHit),
    .restartHit(restartHit),
    .strobe    (strobe),
    .regRdData (regRdData),
    .clkSelBk  (clkSelBk),
    .irqReq    (irqReq),
    .sysRst    (sysRst)
  );

  // R3
  stop_needs_enable_chk: assert property (@(posedge bkClk) disable iff (!rstN)
    $rose(regRdData[BIT_STOP]) |-> $past(regRdData[BIT_EN]));
endmodule

// File: tb/clk_loss_mon_bench.sv
module clk_loss_mon_bench;
  localparam int STOP_CYCLES = 8;
  localparam int RESTART_EDGES = 4;
  localparam int F_EN = 0, F_MODE = 1, F_SEL = 2, F_FLAG = 3, F_STOP = 4;

  logic bkClk = 1'b0, mainClk = 1'b0, rstN = 1'b0;
  logic cpuSrcPll = 1'b0, regWrEn = 1'b0, mainRun = 1'b0;
  logic [4:0] regWrData = '0;
  logic [4:0] regRdData;
  logic clkSelBk, irqReq, sysRst;
  int testCnt = 0, failCnt = 0;

  clk_loss_mon #(.STOP_CYCLES(STOP_CYCLES), .RESTART_EDGES(RESTART_EDGES)) u_clk_loss_mon (
    .bkClk(bkClk), .mainClk(mainClk), .rstN(rstN), .cpuSrcPll(cpuSrcPll),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .clkSelBk(clkSelBk), .irqReq(irqReq), .sysRst(sysRst));

  always #5 bkClk = ~bkClk;
  always begin
    #20;
    if (mainRun) mainClk = ~mainClk;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge bkClk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] d);
    @(negedge bkClk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge bkClk);
    regWrEn = 1'b0;
  endtask

  // flags: {sysRst, irqReq, clkSelBk, stopStat, detFlag}
  function automatic logic [7:0] outs();
    return {3'b0, sysRst, irqReq, clkSelBk, regRdData[F_STOP], regRdData[F_FLAG]};
  endfunction

  function automatic logic [7:0] pack(input logic r, input logic i, input logic s, input logic st, input logic f);
    return {3'b0, r, i, s, st, f};
  endfunction

  task automatic scenario(input logic en, input logic md, input logic pll);
    logic expSel;
    logic [4:0] cfg;
    mainRun = 1'b0;
    rstN = 1'b0;
    cycles(3);
    rstN = 1'b1;
    cycles(2);
    // R1 reset state
    chk("R1", "reset state", {regRdData, sysRst, irqReq, clkSelBk}, 8'h00);

    cpuSrcPll = pll;
    cfg = '0;
    cfg[F_EN] = en; cfg[F_MODE] = md; cfg[F_FLAG] = 1'b1;
    wrReg(cfg);
    mainRun = 1'b1;
    cycles(30);
    // R3 running clock: nothing declared
    chk("R3", "running", outs(), 8'h00);

    @(posedge mainClk);
    mainRun = 1'b0;
    cycles(STOP_CYCLES - 2);
    // R3 not before the window
    chk("R3", "early", outs(), 8'h00);
    cycles(12);
    expSel = en && md && !pll;
    if (!en)      chk("R2", "disabled stop", outs(), 8'h00);
    else if (!md) chk("R4", "reset mode stop", outs(), pack(1, 0, 0, 1, 1));
    else if (!pll) chk("R5", "int stop main src", outs(), pack(0, 1, 1, 1, 1));
    else          chk("R6", "int stop pll src", outs(), pack(0, 1, 0, 1, 1));

    if (en && md) begin
      cfg[F_SEL] = 1'b0;
      wrReg(cfg);
      cycles(1);
      // R10 clear blocked while stopped
      chk("R10", "clear while stopped", {7'b0, clkSelBk}, {7'b0, expSel});
      if (pll) begin
        cfg[F_SEL] = 1'b1;
        wrReg(cfg);
        cycles(1);
        chk("R10", "software set", {7'b0, clkSelBk}, 8'h01);
        expSel = 1'b1;
      end
      cfg[F_SEL] = expSel;
    end

    if (en) begin
      mainRun = 1'b1;
      repeat (RESTART_EDGES - 2) @(posedge mainClk);
      mainRun = 1'b0;
      cycles(STOP_CYCLES + 12);
      // R8 short burst is not a restart
      chk("R8", "short burst", {7'b0, regRdData[F_STOP]}, 8'h01);
    end

    mainRun = 1'b1;
    cycles(40);
    if (!en)      chk("R2", "disabled restart", outs(), 8'h00);
    else if (!md) chk("R4", "reset held over restart", outs(), pack(1, 0, 0, 0, 1));
    else          chk("R7", "int restart", outs(), pack(0, 1, expSel, 0, 1));

    if (en) begin
      cfg[F_FLAG] = 1'b1;
      wrReg(cfg);
      cycles(1);
      // R9 write of 1 keeps the flag
      chk("R9", "flag write one", {6'b0, irqReq, regRdData[F_FLAG]}, {6'b0, md, 1'b1});
      cfg[F_FLAG] = 1'b0;
      wrReg(cfg);
      cycles(1);
      chk("R9", "flag clear", {6'b0, irqReq, regRdData[F_FLAG]}, 8'h00);
      chk("R4", "reset after writes", {7'b0, sysRst}, {7'b0, !md});
      cfg[F_SEL] = 1'b0;
      wrReg(cfg);
      cycles(1);
      // R10 clear allowed once running
      chk("R10", "clear when running", {7'b0, clkSelBk}, 8'h00);
    end
  endtask

  initial begin
    for (int e = 0; e < 2; e++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 2; p++)
          scenario(e[0], m[0], p[0]);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #2_000_000;
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule